// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers interrupt requests from a fixed set of sources, picks the most urgent pending one and hands it to a processor. Each source has a fixed rank given by its vector index. Index 0 is the most urgent, and urgency falls as the index rises. While a routine is in service, only a strictly more urgent request can interrupt it. The controller keeps a stack of the routines it has preempted, so that the lower-ranked work continues once the higher-ranked routine issues its return strobe. Nesting is capped at a fixed depth.

The sources come in two groups:

- **Internal sources.** The lower indices are single-cycle request pulses from on-chip units such as timers, counters and pulse generators.
- **Pin sources.** The upper indices are derived from external input pins. Each pin yields two independent sources, one on its low-to-high transition and one on its high-to-low transition.

Every source has its own enable bit, which can be changed at any time. The processor side sees three things:

- a one-cycle `irq_o` pulse for every grant, including a preemption;
- the vector index of the routine now in service;
- the current nesting depth.

Top module: `nest_irq_ctrl`

## Requirements
- R1: With nothing in service, a pending enabled source is granted one clock after its request is latched. A request is latched at the first rising edge that sees it, so the grant comes two edges after the request is applied. On the grant, `irq_o` pulses for one cycle, `vec_o` shows the source's index and `depth_o` becomes 1.
- R2: When several sources are pending together, the lowest index wins. The others stay pending and are granted later, in index order, as the stack allows.
- R3: A pending request whose index is equal to or greater than the index in service is not granted until that routine returns.
- R4: A pending request with a strictly lower index than the one in service preempts it. Depth rises by one and `vec_o` shows the new index. After the return strobe, `vec_o` again shows the preempted index.
- R5: Depth never exceeds MAX_DEPTH (default 5). A request that would need one more level stays pending and is granted once a return lowers the depth.
- R6: Pin k produces two sources. Its rising edge is index NUM_INT+2k and its falling edge is index NUM_INT+2k+1, where NUM_INT = NUM_SRC-2*NUM_PINS (default 17). A level present on a pin during reset creates no edge.
- R7: A request that arrives while its enable bit is 0 is discarded. Clearing an enable bit also drops that source's pending request.
- R8: `rti_i` pops one level of the stack. A return with an empty stack is ignored: depth stays 0 and no grant is produced.
- R9: No grant is made in a cycle in which `rti_i` is high. A waiting request is granted in the cycle that follows.
- R10: `vec_o` holds its value from a grant until the next grant or return. It reads 0 whenever the depth is 0.
- R11: A grant clears the source's pending request, so a single request yields exactly one grant.
- R12: After reset, `irq_o` is 0, `vec_o` is 0 and `depth_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | NUM_INT | Request pulses from internal sources, indices 0 to NUM_INT-1 |
| pin_i | input | NUM_PINS | External pin levels, edge-detected internally |
| en_i | input | NUM_SRC | Per-source enable, bit i for index i |
| rti_i | input | 1 | Return-from-interrupt strobe |
| irq_o | output | 1 | One-cycle pulse on each grant |
| vec_o | output | IDX_W | Index of the routine in service |
| depth_o | output | DEPTH_W | Current nesting depth |

## Verification
The bench uses the default parameters: 49 sources, 16 pins and a cap of five levels. This puts the first and last pin sources (indices 17 and 48) and a completely filled stack within reach. With these values, a sixth request can be held at the cap and then released by a single return, and the stack can be unwound all the way down and one level past empty.

// File: rtl/nic_pkg.sv
// Package: default sizes shared by the nested interrupt controller and its parts.
// Assumes: widths are derived locally from these defaults by each module.
package nic_pkg;
    localparam int NIC_NUM_SRC   = 49;
    localparam int NIC_NUM_PINS  = 16;
    localparam int NIC_MAX_DEPTH = 5;
endpackage

// File: rtl/nic_edge_src.sv
// Pin edge detector: turns each pin's level into a rising-edge and a
// falling-edge request pulse (rising at bit 2k, falling at bit 2k+1).
// Assumes: pins are already synchronous to clk. During reset the pin
// levels are sampled, so a level held through reset creates no edge.
module nic_edge_src #(
    parameter int NUM_PINS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pin_i,
    output logic [2*NUM_PINS-1:0] edge_o
);
    logic [NUM_PINS-1:0] pin_q;

    // Remember the previous pin levels; reset loads the live levels.
    always_ff @(posedge clk) begin
        pin_q <= pin_i;
    end

    for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
        assign edge_o[2*k]   =  pin_i[k] & ~pin_q[k] & rst_n;
        assign edge_o[2*k+1] = ~pin_i[k] &  pin_q[k] & rst_n;
    end
endmodule

// File: rtl/nic_pend.sv
// Pending register: latches enabled requests, drops disabled ones and
// clears the bit of the source being granted.
// Assumes: at most one clear per cycle, named by index.
module nic_pend #(
    parameter int NUM_SRC = 49,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] raw_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic               clr_vld_i,
    input  logic [IDX_W-1:0]   clr_idx_i,
    output logic [NUM_SRC-1:0] pend_o
);
    logic [NUM_SRC-1:0] clr_mask;

    // Decode the granted index into a one-hot clear mask.
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            clr_mask[i] = clr_vld_i && (clr_idx_i == IDX_W'(i));
        end
    end

    // Update pending bits: set on enabled request, clear on grant or disable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_o <= '0;
        end else begin
            pend_o <= (pend_o | raw_i) & en_i & ~clr_mask;
        end
    end

    AST_DISABLED_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_o & ~$past(en_i)) == '0)); // R7
endmodule

// File: rtl/nic_arbiter.sv
// Fixed-priority arbiter: reports the lowest-index pending source.
// Assumes: index 0 is the most urgent; purely combinational.
module nic_arbiter #(
    parameter int NUM_SRC = 49,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] pend_i,
    output logic               vld_o,
    output logic [IDX_W-1:0]   idx_o
);
    // Scan from the least urgent down so the lowest set index wins.
    always_comb begin
        vld_o = 1'b0;
        idx_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                vld_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/nic_stack.sv
// In-service stack: holds the vector of every nested routine; the top
// entry is the one running. A pop on an empty stack is ignored.
// Assumes: push is never requested when full and never with pop.
module nic_stack #(
    parameter int IDX_W     = 6,
    parameter int MAX_DEPTH = 5,
    localparam int DEPTH_W  = $clog2(MAX_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_i,
    input  logic [IDX_W-1:0]   push_idx_i,
    input  logic               pop_i,
    output logic [DEPTH_W-1:0] depth_o,
    output logic [IDX_W-1:0]   top_o,
    output logic               full_o,
    output logic               empty_o
);
    logic [IDX_W-1:0] stk_q [MAX_DEPTH];

    assign full_o  = (depth_o == DEPTH_W'(MAX_DEPTH));
    assign empty_o = (depth_o == '0);

    // Track the depth: grow on push, shrink on a pop that has something to pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth_o <= '0;
        end else if (push_i && !full_o) begin
            depth_o <= depth_o + 1'b1;
        end else if (pop_i && !empty_o) begin
            depth_o <= depth_o - 1'b1;
        end
    end

    // Write the pushed vector into the slot just above the current top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_DEPTH; i++) stk_q[i] <= '0;
        end else begin
            for (int i = 0; i < MAX_DEPTH; i++) begin
                if (push_i && depth_o == DEPTH_W'(i)) stk_q[i] <= push_idx_i;
            end
        end
    end

    // Select the running vector; zero when nothing is in service.
    always_comb begin
        top_o = '0;
        for (int i = 0; i < MAX_DEPTH; i++) begin
            if (depth_o == DEPTH_W'(i + 1)) top_o = stk_q[i];
        end
    end

    AST_DEPTH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        depth_o <= DEPTH_W'(MAX_DEPTH)); // R5
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && empty_o) |=> empty_o); // R8
    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (depth_o == $past(depth_o) + 1'b1) && (top_o == $past(push_idx_i))); // R4
    AST_TOP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_i && !pop_i) |=> $stable(top_o)); // R10
endmodule

// File: rtl/nest_irq_ctrl.sv
// Nested priority interrupt controller top. Internal request pulses and
// pin edges feed a pending register; the most urgent pending source is
// granted if the stack has room and it beats the routine in service.
// Assumes: req_i pulses and pin_i levels are synchronous to clk; a return
// strobe blocks grants in its own cycle.
module nest_irq_ctrl
    import nic_pkg::*;
#(
    parameter int NUM_SRC   = NIC_NUM_SRC,
    parameter int NUM_PINS  = NIC_NUM_PINS,
    parameter int MAX_DEPTH = NIC_MAX_DEPTH,
    localparam int NUM_INT  = NUM_SRC - 2 * NUM_PINS,
    localparam int IDX_W    = $clog2(NUM_SRC),
    localparam int DEPTH_W  = $clog2(MAX_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_INT-1:0] req_i,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic               rti_i,
    output logic               irq_o,
    output logic [IDX_W-1:0]   vec_o,
    output logic [DEPTH_W-1:0] depth_o
);
    logic [2*NUM_PINS-1:0] pin_edge;
    logic [NUM_SRC-1:0]    raw_req;
    logic [NUM_SRC-1:0]    pend;
    logic                  win_vld;
    logic [IDX_W-1:0]      win_idx;
    logic                  grant;
    logic                  stk_full;
    logic                  stk_empty;
    logic [IDX_W-1:0]      top_idx;

    nic_edge_src #(.NUM_PINS(NUM_PINS)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .edge_o (pin_edge)
    );

    assign raw_req = {pin_edge, req_i};

    nic_pend #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_i     (raw_req),
        .en_i      (en_i),
        .clr_vld_i (grant),
        .clr_idx_i (win_idx),
        .pend_o    (pend)
    );

    nic_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .pend_i (pend),
        .vld_o  (win_vld),
        .idx_o  (win_idx)
    );

    // Grant when a winner exists, no return is in progress, there is room,
    // and the winner is strictly more urgent than the routine in service.
    assign grant = win_vld && !rti_i && !stk_full && (stk_empty || (win_idx < top_idx));

    nic_stack #(.IDX_W(IDX_W), .MAX_DEPTH(MAX_DEPTH)) u_stk (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (grant),
        .push_idx_i (win_idx),
        .pop_i      (rti_i),
        .depth_o    (depth_o),
        .top_o      (top_idx),
        .full_o     (stk_full),
        .empty_o    (stk_empty)
    );

    // Register the grant as a one-cycle request pulse to the processor.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= grant;
    end

    assign vec_o = top_idx;

    AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> pend[win_idx]); // R1
    AST_IRQ_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (depth_o != '0)); // R1
    AST_NO_GRANT_ON_RTI: assert property (@(posedge clk) disable iff (!rst_n)
        rti_i |=> !irq_o); // R9
    AST_GRANT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !raw_req[win_idx]) |=> !pend[$past(win_idx)]); // R11
endmodule

// File: tb/tb_nest_irq_ctrl.sv
module tb_nest_irq_ctrl;
    localparam int NUM_SRC = 49;
    localparam int NUM_PINS = 16;
    localparam int NUM_INT = NUM_SRC - 2 * NUM_PINS;

    typedef struct packed { logic [5:0] v; logic [2:0] d; } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NUM_INT-1:0] req = '0;
    logic [NUM_PINS-1:0] pin = 16'h8000;
    logic [NUM_SRC-1:0] en = '1;
    logic rti = 1'b0;
    logic irq;
    logic [5:0] vec;
    logic [2:0] depth;

    exp_t q[$];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    nest_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .pin_i(pin), .en_i(en),
        .rti_i(rti), .irq_o(irq), .vec_o(vec), .depth_o(depth)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_grant(int v, int d);
        exp_t e;
        e.v = 6'(v);
        e.d = 3'(d);
        q.push_back(e);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(int idx);
        req[idx] = 1'b1;
        @(negedge clk);
        req[idx] = 1'b0;
    endtask

    task automatic ret();
        rti = 1'b1;
        @(negedge clk);
        rti = 1'b0;
    endtask

    // Monitor: each grant pulse pops the scoreboard and compares.
    always @(negedge clk) begin
        if (rst_n && irq && !done) begin
            if (q.size() == 0) begin
                chk("R11 unexpected grant vec", int'(vec), -1);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk("R1 grant vec", int'(vec), int'(e.v));
                chk("R1 grant depth", int'(depth), int'(e.d));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(3);
        // R12 reset state; R6 pin 15 high through reset gives no edge
        chk("R12 irq", int'(irq), 0);
        chk("R12 vec", int'(vec), 0);
        chk("R12 depth", int'(depth), 0);

        // R1 single grant
        expect_grant(5, 1);
        pulse(5); idle(3);
        chk("R10 vec held", int'(vec), 5);
        chk("R1 depth", int'(depth), 1);

        // R3 equal and less urgent wait
        pulse(9); pulse(5); idle(4);
        chk("R3 depth", int'(depth), 1);
        chk("R3 vec", int'(vec), 5);
        // R9 return then grant next cycle; R2 order 5 before 9
        expect_grant(5, 1);
        ret();
        chk("R9 depth after rti", int'(depth), 0);
        idle(3);
        expect_grant(9, 1);
        ret(); idle(3);
        ret(); idle(2);
        chk("R8 depth", int'(depth), 0);
        chk("R10 vec idle", int'(vec), 0);

        // R4 preemption and resume
        expect_grant(10, 1);
        pulse(10); idle(3);
        expect_grant(3, 2);
        pulse(3); idle(3);
        chk("R4 depth", int'(depth), 2);
        ret(); idle(1);
        chk("R4 resume vec", int'(vec), 10);
        chk("R4 resume depth", int'(depth), 1);
        ret(); idle(2);

        // R5 depth cap
        expect_grant(16, 1); pulse(16); idle(3);
        expect_grant(14, 2); pulse(14); idle(3);
        expect_grant(12, 3); pulse(12); idle(3);
        expect_grant(10, 4); pulse(10); idle(3);
        expect_grant(8, 5);  pulse(8);  idle(3);
        pulse(2); idle(4);
        chk("R5 capped depth", int'(depth), 5);
        chk("R5 capped vec", int'(vec), 8);
        expect_grant(2, 5);
        ret(); idle(3);
        chk("R5 refilled vec", int'(vec), 2);
        ret(); idle(1);
        chk("R8 pop vec", int'(vec), 10);
        ret(); ret(); ret(); idle(1);
        chk("R8 pop vec deep", int'(vec), 16);
        ret(); idle(1);
        chk("R8 empty", int'(depth), 0);
        ret(); idle(3);
        chk("R8 empty pop ignored", int'(depth), 0);

        // R2 simultaneous requests
        expect_grant(4, 1);
        req[7] = 1'b1; req[4] = 1'b1;
        @(negedge clk);
        req = '0;
        idle(4);
        expect_grant(7, 1);
        ret(); idle(3);
        ret(); idle(2);

        // R6 pin edges
        expect_grant(23, 1);
        pin[3] = 1'b1; idle(4);
        ret(); idle(2);
        expect_grant(24, 1);
        pin[3] = 1'b0; idle(4);
        ret(); idle(2);
        expect_grant(17, 1);
        pin[0] = 1'b1; idle(4);
        ret(); idle(2);
        expect_grant(48, 1);
        pin[15] = 1'b0; idle(4);
        chk("R6 pin15 falling vec", int'(vec), 48);
        ret(); idle(2);

        // R7 request while disabled is discarded
        en[6] = 1'b0;
        pulse(6); idle(2);
        en[6] = 1'b1; idle(4);
        chk("R7 discarded", int'(depth), 0);
        // R7 disabling clears a pending request
        expect_grant(1, 1);
        pulse(1); idle(3);
        pulse(6); idle(2);
        en[6] = 1'b0; idle(2);
        ret(); idle(3);
        en[6] = 1'b1; idle(4);
        chk("R7 pending dropped", int'(depth), 0);
        chk("R7 vec idle", int'(vec), 0);

        chk("R11 scoreboard drained", q.size(), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule